// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits between a host bus and the control logic of a small flash array. It watches write strobes, each carrying an address and a 16-bit data word. It recognises the unlock-prefixed command sequences that the array understands: a fixed write of 0xAA to 0x5555, then 0x55 to 0x2AAA, then a command byte. For each command it recognises, it raises a one-clock command pulse. The erase commands use a second unlock pair before their final byte. Word program takes one more write that carries the target address and data. The block latches that address and data, and the sector address of a sector erase, onto shared outputs that are valid while the pulse is high.

The block also keeps the current read mode, either normal array read or identification. While identification mode is active, a read strobe makes the block drive the manufacturer code or the device code onto its own data output. A read strobe in the middle of a sequence abandons that sequence. A write strobe that stays high for fewer clocks than a set minimum is treated as noise. Executing the commands and storing the array are left to the surrounding logic.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset is asserted (rst_ni low), every command pulse is low, id_mode_o is 0, id_drive_o is 0, cmd_addr_o is 0 and cmd_data_o is 0.
- R2: The writes AA@5555, 55@2AAA, A0@5555 followed by any write (A,D) give exactly one word_prog_o pulse, with cmd_addr_o equal to A (all ADDR_W bits) and cmd_data_o equal to D (all 16 bits).
- R3: The writes AA@5555, 55@2AAA, 90@5555 give one id_enter_o pulse and set id_mode_o to 1. The writes AA@5555, 55@2AAA, F0@5555 give one id_leave_o pulse and clear id_mode_o.
- R4: From the idle step, a single write whose low data byte is F0, at any address, gives one id_leave_o pulse and clears id_mode_o.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, followed by a sixth write, produce one of three pulses. If the sixth write is 10@5555, chip_erase_o pulses. If it is 40@5555, boot_lock_o pulses. If it is 30 at any address A, sector_erase_o pulses with cmd_addr_o equal to A.
- R6: Only data bits 7..0 take part in matching a command byte, and only address bits 14..0 take part in matching 0x5555 and 0x2AAA. Address bits above 14 and data bits 15..8 never change which command is decoded.
- R7: A write that does not match the expected address and byte for the current step returns the decoder to idle and produces no pulse. Any writes that follow must start a new sequence from the beginning.
- R8: A read strobe (rd_i high) while a sequence is partly entered abandons it. A following write that would have completed the sequence produces no pulse.
- R9: While id_mode_o is 1 and rd_i is 1, id_drive_o is 1 and id_data_o shows 0x00DA at address 0, 0x003E at address 1, and 0x0000 at any other address. While id_mode_o is 0, id_drive_o and id_data_o are 0.
- R10: A write strobe counts only if wr_i stays high for at least MIN_WR_CLKS consecutive clocks. Such a strobe counts once however long it stays high. Its address and data are taken on the MIN_WR_CLKS-th clock of the strobe.
- R11: Asserting reset in the middle of a sequence discards it. The writes that would have completed it afterwards give no pulse.
- R12: Each command pulse lasts exactly one clock, and no two command pulses are high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, level, held for several clocks |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| chip_erase_o | output | 1 | Chip erase command pulse |
| sector_erase_o | output | 1 | Sector erase command pulse |
| word_prog_o | output | 1 | Word program command pulse |
| boot_lock_o | output | 1 | Boot block lockout command pulse |
| id_enter_o | output | 1 | Identification entry pulse |
| id_leave_o | output | 1 | Identification exit pulse |
| cmd_addr_o | output | ADDR_W | Latched program or sector address |
| cmd_data_o | output | DATA_W | Latched program data |
| id_mode_o | output | 1 | 1 while identification mode is active |
| id_drive_o | output | 1 | 1 while id_data_o drives an identification read |
| id_data_o | output | DATA_W | Identification code read data |

## Verification
The bench checks the edges of the strobe filter: a strobe one clock shorter than the minimum, and a strobe far longer than it. A filter off by one would accept the glitch, and a filter that re-arms would count a long strobe twice; either way a sequence would complete when it should not. Unlock writes are sent with A16 set and junk in the upper data byte. A decoder that compares full words would then miss commands it should decode. Sequences are cut by a wrong write, by a read and by reset, and then "completed". A decoder that resumes where it stopped would fire a program pulse in those cases. Random program and sector-erase targets check that the latched address and data come from the final write and not from an unlock write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] UNLK_A = 15'h5555;
  localparam logic [CMD_AW-1:0] UNLK_B = 15'h2AAA;

  localparam logic [7:0] B_AA    = 8'hAA;
  localparam logic [7:0] B_55    = 8'h55;
  localparam logic [7:0] B_PROG  = 8'hA0;
  localparam logic [7:0] B_IDIN  = 8'h90;
  localparam logic [7:0] B_IDOUT = 8'hF0;
  localparam logic [7:0] B_ERASE = 8'h80;
  localparam logic [7:0] B_CHIP  = 8'h10;
  localparam logic [7:0] B_SECT  = 8'h30;
  localparam logic [7:0] B_LOCK  = 8'h40;

  localparam logic [15:0] MFR_CODE = 16'h00DA;
  localparam logic [15:0] DEV_CODE = 16'h003E;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5
  } seq_st_e;

  typedef struct packed {
    logic chip;
    logic sect;
    logic prog;
    logic lock;
    logic id_in;
    logic id_out;
  } cmd_pulse_t;
endpackage

// File: rtl/wr_strobe_filter.sv
module wr_strobe_filter #(
  parameter int MIN_CLKS = 3,
  parameter int AW       = 17,
  parameter int DW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          ev_o,
  output logic [AW-1:0] ev_addr_o,
  output logic [DW-1:0] ev_data_o
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(MIN_CLKS);
  localparam logic [CW-1:0] CNT_HIT = CW'(MIN_CLKS - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      ev_o      <= 1'b0;
      ev_addr_o <= '0;
      ev_data_o <= '0;
    end else begin
      ev_o <= 1'b0;
      if (!wr_i) begin
        run_q <= '0;
      end else begin
        if (run_q != CNT_SAT) run_q <= run_q + 1'b1;
        // fire once, on the MIN_CLKS-th high clock
        if (run_q == CNT_HIT) begin
          ev_o      <= 1'b1;
          ev_addr_o <= addr_i;
          ev_data_o <= data_i;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_i,
  input  logic [AW-1:0] ev_addr_i,
  input  logic [DW-1:0] ev_data_i,
  input  logic          rd_i,
  output cmd_pulse_t    pulse_o,
  output logic          id_mode_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o
);
  seq_st_e    st_q, st_d;
  cmd_pulse_t pulse_d;
  logic       mode_d;
  logic       latch_d;

  logic [CMD_AW-1:0] ca;
  logic [7:0]        cb;
  logic              at_a, at_b;

  assign ca   = ev_addr_i[CMD_AW-1:0];
  assign cb   = ev_data_i[7:0];
  assign at_a = (ca == UNLK_A);
  assign at_b = (ca == UNLK_B);

  always_comb begin
    st_d    = st_q;
    pulse_d = '0;
    mode_d  = id_mode_o;
    latch_d = 1'b0;
    if (rd_i) begin
      st_d = S_IDLE;
    end else if (ev_i) begin
      st_d = S_IDLE;
      unique case (st_q)
        S_IDLE: begin
          if (at_a && cb == B_AA) begin
            st_d = S_U1;
          end else if (cb == B_IDOUT) begin
            pulse_d.id_out = 1'b1;
            mode_d         = 1'b0;
          end
        end
        S_U1: if (at_b && cb == B_55) st_d = S_U2;
        S_U2: begin
          if (at_a) begin
            unique case (cb)
              B_PROG:  st_d = S_PROG;
              B_ERASE: st_d = S_E3;
              B_IDIN: begin
                pulse_d.id_in = 1'b1;
                mode_d        = 1'b1;
              end
              B_IDOUT: begin
                pulse_d.id_out = 1'b1;
                mode_d         = 1'b0;
              end
              default: ;
            endcase
          end
        end
        S_PROG: begin
          pulse_d.prog = 1'b1;
          latch_d      = 1'b1;
        end
        S_E3: if (at_a && cb == B_AA) st_d = S_E4;
        S_E4: if (at_b && cb == B_55) st_d = S_E5;
        S_E5: begin
          if (cb == B_SECT) begin
            pulse_d.sect = 1'b1;
            latch_d      = 1'b1;
          end else if (at_a && cb == B_CHIP) begin
            pulse_d.chip = 1'b1;
          end else if (at_a && cb == B_LOCK) begin
            pulse_d.lock = 1'b1;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      pulse_o    <= '0;
      id_mode_o  <= 1'b0;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
    end else begin
      st_q      <= st_d;
      pulse_o   <= pulse_d;
      id_mode_o <= mode_d;
      if (latch_d) begin
        cmd_addr_o <= ev_addr_i;
        cmd_data_o <= ev_data_i;
      end
    end
  end
endmodule

// File: rtl/id_code_rom.sv
module id_code_rom
  import flash_cmd_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  logic          id_mode_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output logic          drive_o,
  output logic [DW-1:0] data_o
);
  localparam logic [AW-1:0] ADR_MFR = AW'(0);
  localparam logic [AW-1:0] ADR_DEV = AW'(1);

  always_comb begin
    drive_o = id_mode_i && rd_i;
    data_o  = '0;
    if (drive_o) begin
      if (addr_i == ADR_MFR)      data_o = DW'(MFR_CODE);
      else if (addr_i == ADR_DEV) data_o = DW'(DEV_CODE);
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter int MIN_WR_CLKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              chip_erase_o,
  output logic              sector_erase_o,
  output logic              word_prog_o,
  output logic              boot_lock_o,
  output logic              id_enter_o,
  output logic              id_leave_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              id_mode_o,
  output logic              id_drive_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic              ev;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;
  cmd_pulse_t        pulse;

  wr_strobe_filter #(
    .MIN_CLKS(MIN_WR_CLKS), .AW(ADDR_W), .DW(DATA_W)
  ) u_filt (
    .clk_i, .rst_ni, .wr_i, .addr_i, .data_i,
    .ev_o(ev), .ev_addr_o(ev_addr), .ev_data_o(ev_data)
  );

  cmd_seq_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .ev_i(ev), .ev_addr_i(ev_addr), .ev_data_i(ev_data),
    .rd_i,
    .pulse_o(pulse), .id_mode_o, .cmd_addr_o, .cmd_data_o
  );

  id_code_rom #(.AW(ADDR_W), .DW(DATA_W)) u_rom (
    .id_mode_i(id_mode_o), .rd_i, .addr_i,
    .drive_o(id_drive_o), .data_o(id_data_o)
  );

  assign chip_erase_o   = pulse.chip;
  assign sector_erase_o = pulse.sect;
  assign word_prog_o    = pulse.prog;
  assign boot_lock_o    = pulse.lock;
  assign id_enter_o     = pulse.id_in;
  assign id_leave_o     = pulse.id_out;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic rd_i,
  input logic chip_erase_o,
  input logic sector_erase_o,
  input logic word_prog_o,
  input logic boot_lock_o,
  input logic id_enter_o,
  input logic id_leave_o,
  input logic id_mode_o,
  input logic id_drive_o
);
  logic any_cmd;
  assign any_cmd = chip_erase_o | sector_erase_o | word_prog_o |
                   boot_lock_o | id_enter_o | id_leave_o;

  assert_onehot_cmd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chip_erase_o, sector_erase_o, word_prog_o, boot_lock_o, id_enter_o, id_leave_o}));

  assert_one_clk_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd |=> !any_cmd);

  assert_from_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd |-> $past(wr_i, 2));

  assert_mode_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> id_enter_o);

  assert_leave_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_leave_o |-> !id_mode_o);

  assert_drive_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_drive_o |-> (id_mode_o && rd_i));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
  .chip_erase_o(chip_erase_o), .sector_erase_o(sector_erase_o),
  .word_prog_o(word_prog_o), .boot_lock_o(boot_lock_o),
  .id_enter_o(id_enter_o), .id_leave_o(id_leave_o),
  .id_mode_o(id_mode_o), .id_drive_o(id_drive_o)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int MINW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic chip_o, sect_o, prog_o, lock_o, ent_o, lev_o, mode_o, drv_o;
  logic [AW-1:0] caddr_o;
  logic [DW-1:0] cdata_o, iddata_o;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .MIN_WR_CLKS(MINW)) dut (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .data_i,
    .chip_erase_o(chip_o), .sector_erase_o(sect_o), .word_prog_o(prog_o),
    .boot_lock_o(lock_o), .id_enter_o(ent_o), .id_leave_o(lev_o),
    .cmd_addr_o(caddr_o), .cmd_data_o(cdata_o), .id_mode_o(mode_o),
    .id_drive_o(drv_o), .id_data_o(iddata_o)
  );

  int n_chk = 0, n_bad = 0;
  int c_chip = 0, c_sect = 0, c_prog = 0, c_lock = 0, c_ent = 0, c_lev = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit done = 0;

  always @(negedge clk) if (rst_ni) begin
    if (chip_o) c_chip++;
    if (sect_o) begin c_sect++; last_addr = caddr_o; end
    if (prog_o) begin c_prog++; last_addr = caddr_o; last_data = cdata_o; end
    if (lock_o) c_lock++;
    if (ent_o)  c_ent++;
    if (lev_o)  c_lev++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, int len = MINW);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; data_i = d;
    repeat (len) @(negedge clk);
    wr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock();
    wr(17'h05555, 16'h00AA);
    wr(17'h02AAA, 16'h0055);
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [DW-1:0] d);
    unlock(); wr(17'h05555, 16'h00A0); wr(a, d); settle();
  endtask

  task automatic do_six(logic [AW-1:0] a, logic [DW-1:0] d);
    unlock(); wr(17'h05555, 16'h0080); unlock(); wr(a, d); settle();
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [DW-1:0] exp, logic exp_drv, string req);
    @(negedge clk); rd_i = 1'b1; addr_i = a;
    #1;
    check(req, {15'd0, drv_o, iddata_o}, {15'd0, exp_drv, exp});
    @(negedge clk); rd_i = 1'b0;
  endtask

  function automatic logic [DW-1:0] id_expect(logic [AW-1:0] a);
    return (a == 0) ? 16'h00DA : (a == 1) ? 16'h003E : 16'h0000;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {chip_o, sect_o, prog_o, lock_o, ent_o, lev_o, mode_o, drv_o}, 0);
    check("R1 addr/data", {caddr_o, cdata_o} == 0, 1);
    rst_ni = 1'b1;
    settle();

    // R2 directed program
    do_prog(17'h1ABCD, 16'hBEEF);
    check("R2 count", c_prog, 1);
    check("R2 addr", last_addr, 17'h1ABCD);
    check("R2 data", last_data, 16'hBEEF);

    // R3 enter id, R9 reads
    unlock(); wr(17'h05555, 16'h0090); settle();
    check("R3 enter", c_ent, 1);
    check("R3 mode", mode_o, 1);
    rd_chk(17'h00000, 16'h00DA, 1, "R9 mfr");
    rd_chk(17'h00001, 16'h003E, 1, "R9 dev");
    rd_chk(17'h00002, 16'h0000, 1, "R9 other");
    unlock(); wr(17'h05555, 16'h00F0); settle();
    check("R3 leave", c_lev, 1);
    check("R3 mode off", mode_o, 0);
    rd_chk(17'h00000, 16'h0000, 0, "R9 not id");

    // R4 single-write exit
    unlock(); wr(17'h05555, 16'h0090); settle();
    wr(17'h13579, 16'h77F0); settle();
    check("R4 leave", c_lev, 2);
    check("R4 mode", mode_o, 0);

    // R5 six-cycle commands
    do_six(17'h05555, 16'h0010);
    check("R5 chip", c_chip, 1);
    do_six(17'h05555, 16'h0040);
    check("R5 lock", c_lock, 1);
    do_six(17'h0C123, 16'h0030);
    check("R5 sect", c_sect, 1);
    check("R5 sect addr", last_addr, 17'h0C123);
    do_six(17'h04555, 16'h0010);
    check("R5 chip needs 5555", c_chip, 1);

    // R6 upper bits ignored
    p = c_prog;
    wr(17'h1D555, 16'hC3AA); wr(17'h1AAAA, 16'h9955); wr(17'h15555, 16'hFFA0);
    wr(17'h00042, 16'h1234); settle();
    check("R6 masked prog", c_prog, p + 1);
    check("R6 data", last_data, 16'h1234);

    // R7 mismatch resets the sequence
    p = c_prog;
    unlock(); wr(17'h05555, 16'h00A1); wr(17'h05555, 16'h00A0); wr(17'h00010, 16'h5A5A);
    settle();
    check("R7 no prog", c_prog, p);
    wr(17'h05555, 16'h00AA); wr(17'h02AAB, 16'h0055); wr(17'h05555, 16'h00A0);
    wr(17'h00010, 16'h5A5A); settle();
    check("R7 wrong addr", c_prog, p);

    // R8 read aborts
    unlock(); wr(17'h05555, 16'h00A0);
    @(negedge clk); rd_i = 1'b1; addr_i = 17'h00100; @(negedge clk); rd_i = 1'b0;
    wr(17'h00020, 16'h1111); settle();
    check("R8 abort", c_prog, p);

    // R11 reset aborts
    unlock(); wr(17'h05555, 16'h00A0);
    @(negedge clk); rst_ni = 1'b0; @(negedge clk); rst_ni = 1'b1;
    wr(17'h00020, 16'h2222); settle();
    check("R11 abort", c_prog, p);

    // R10 glitch filter
    wr(17'h05555, 16'h00AA, MINW - 1);
    wr(17'h02AAA, 16'h0055); wr(17'h05555, 16'h00A0); wr(17'h00030, 16'h3333);
    settle();
    check("R10 glitch", c_prog, p);
    wr(17'h05555, 16'h00AA, 9); wr(17'h02AAA, 16'h0055, 9);
    wr(17'h05555, 16'h00A0, 9); wr(17'h00031, 16'h4444, 9); settle();
    check("R10 long strobe", c_prog, p + 1);
    check("R10 data", last_data, 16'h4444);

    // random mix
    void'($urandom(32'h5EED1234));
    for (int it = 0; it < 60; it++) begin
      int kind;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      kind = $urandom_range(0, 2);
      a = AW'($urandom);
      d = DW'($urandom);
      if (kind == 0) begin
        p = c_prog;
        do_prog(a, d);
        check("R2 rand", c_prog, p + 1);
        check("R2 rand addr", last_addr, a);
        check("R2 rand data", last_data, d);
      end else if (kind == 1) begin
        p = c_sect;
        do_six(a, {d[15:8], 8'h30});
        check("R5 rand sect", c_sect, p + 1);
        check("R5 rand addr", last_addr, a);
      end else begin
        unlock(); wr(17'h05555, {d[15:8], 8'h90}); settle();
        a = AW'($urandom_range(0, 3));
        rd_chk(a, id_expect(a), 1, "R9 rand");
        wr(AW'($urandom), {d[15:8], 8'hF0}); settle();
        check("R4 rand", mode_o, 0);
      end
    end
    check("R12 no stray", c_chip + c_lock, 2);
    summary();
  end
endmodule